// File: doc/BRIEF.md
# SSB Receive Demodulator Datapath

This block turns a pair of quadrature baseband sample streams (I and Q, 12-bit unsigned converter codes arriving at the nominal 62.5 kHz rate) into an upper-sideband audio level for a pulse-width DAC. Each channel is re-centred around zero and a running DC estimate is removed from it. The cleaned samples then enter a 15-tap low-pass filter. Only one result in four is computed, so the filtered streams run at a quarter of the input rate.

The decimated Q stream passes through a sparse, antisymmetric 15-tap Hilbert transformer, which gives it a 90-degree phase shift. The Hilbert result is subtracted from the centre tap of the decimated I line, which carries the matching group delay. The difference is halved, moved up to the middle of the DAC range and clipped to the legal span of DAC codes.

The upstream sampler presents one I/Q pair per `in_valid` pulse, at any spacing. The downstream PWM stage takes `out_level` whenever `out_valid` pulses.

Top module: `ssbrx_demod`

## Requirements
- R1: While reset is high, and in the first cycle after it falls, `out_valid` is 0 and `out_level` is 125, the middle of the 0..250 DAC span.
- R2: Bits 15..12 of `in_i` and `in_q` are ignored. Only bits 11..0 are used, read as an unsigned code.
- R3: For each accepted sample, 2048 is first subtracted from the 12-bit code, giving x. The channel's DC estimate is then updated as dc = dc + (x>>>7) - (dc>>>7), with arithmetic shifts, and the value stored in the raw line is x minus the updated dc.
- R4: Each channel's filter weights its 15 raw-line entries, oldest to newest, by 3,3,5,7,9,10,11,11,11,10,9,7,5,3,3. It adds them in a 32-bit signed sum, shifts the sum arithmetically right by 8 and stores the result as a 16-bit signed decimated sample. I and Q have separate filters.
- R5: The raw lines advance only on cycles where `in_valid` is high. The filters and all later stages run only for the 4th, 8th, 12th, ... accepted sample after reset, so N accepted samples yield exactly N/4 outputs, rounded down. Input data on cycles where `in_valid` is low has no effect.
- R6: With q0 the oldest and q14 the newest of the last 15 decimated Q values, the Hilbert output is ((q0-q14)*315 + (q2-q12)*440 + (q4-q10)*734 + (q6-q8)*2202) >>> 12.
- R7: The level is (I7 - H)/2 + 125. I7 is the centre entry of the decimated I line and H is the Hilbert output. The halving truncates toward zero.
- R8: Levels above 250 are output as 250 and levels below 0 as 0. `out_level` never exceeds 250.
- R9: `out_valid` is a single-cycle pulse that rises in the third cycle after the clock edge that accepts the 4th, 8th, ... sample. `out_level` changes only together with that pulse and holds its value in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Qualifies the I/Q pair on this cycle |
| in_i | input | 16 | In-phase converter code (low 12 bits used) |
| in_q | input | 16 | Quadrature converter code (low 12 bits used) |
| out_valid | output | 1 | One-cycle pulse with each new audio level |
| out_level | output | 8 | Audio DAC level, 0..250 |

## Verification
The hardest states to reach are the clip rails and the long-memory DC tracker. Stimulus reaches both with long runs that step the I input to a full-scale code: before the tracker has absorbed the offset, the filtered level goes well past either end of the DAC span. A table of runs covers constant, square, sawtooth and quadrature-sine inputs. Some runs insert idle gaps carrying junk data, and some set the unused upper input bits. Each run is compared sample by sample against a bench model built from the formulas in the requirements. Directed tests then measure the exact output latency and the decimation count across idle cycles.

// File: rtl/ssbrx_pkg.sv
package ssbrx_pkg;

   localparam int NTAP = 15;

   typedef logic signed [15:0] smp_t;
   typedef logic signed [31:0] acc_t;

   // symmetric low-pass weights, index 0 = oldest
   function automatic int lpf_coef(int k);
      int m;
      m = (k <= NTAP/2) ? k : NTAP - 1 - k;
      case (m)
         0, 1:    return 3;
         2:       return 5;
         3:       return 7;
         4:       return 9;
         5:       return 10;
         default: return 11;
      endcase
   endfunction

   // antisymmetric, odd taps zero, index 0 = oldest
   function automatic int hil_coef(int k);
      case (k)
         0:       return 315;
         2:       return 440;
         4:       return 734;
         6:       return 2202;
         8:       return -2202;
         10:      return -734;
         12:      return -440;
         14:      return -315;
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/ssbrx_dcblock.sv
module ssbrx_dcblock
   import ssbrx_pkg::*;
#(
   parameter int SAMPLE_W = 16,
   parameter int ADC_BITS = 12,
   parameter int DC_SHIFT = 7
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                en,
   input  logic [SAMPLE_W-1:0] sample,
   output smp_t                dc_free
);

   localparam smp_t MID = smp_t'(1 << (ADC_BITS - 1));

   smp_t x, dc_q, dc_d;

   always_comb begin
      x       = smp_t'(sample[ADC_BITS-1:0]) - MID;
      dc_d    = dc_q + (x >>> DC_SHIFT) - (dc_q >>> DC_SHIFT);
      dc_free = x - dc_d;
   end

   always_ff @(posedge clk) begin
      if (rst)     dc_q <= '0;
      else if (en) dc_q <= dc_d;
   end

   if (SAMPLE_W > ADC_BITS) begin : g_hi
      logic unused_hi;
      assign unused_hi = ^sample[SAMPLE_W-1:ADC_BITS];
   end

endmodule

// File: rtl/ssbrx_chan.sv
module ssbrx_chan
   import ssbrx_pkg::*;
#(
   parameter int SAMPLE_W  = 16,
   parameter int ADC_BITS  = 12,
   parameter int DC_SHIFT  = 7,
   parameter int FIR_SHIFT = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                smp_en,
   input  logic                fir_en,
   input  logic [SAMPLE_W-1:0] sample,
   output smp_t [NTAP-1:0]     dec_line
);

   smp_t            dc_free;
   smp_t [NTAP-1:0] raw_line;
   acc_t            fir_acc;

   ssbrx_dcblock #(
      .SAMPLE_W (SAMPLE_W),
      .ADC_BITS (ADC_BITS),
      .DC_SHIFT (DC_SHIFT)
   ) u_dc (
      .clk     (clk),
      .rst     (rst),
      .en      (smp_en),
      .sample  (sample),
      .dc_free (dc_free)
   );

   // newest entry sits at index NTAP-1
   always_ff @(posedge clk) begin
      if (rst)         raw_line <= '0;
      else if (smp_en) raw_line <= {dc_free, raw_line[NTAP-1:1]};
   end

   always_comb begin
      fir_acc = '0;
      for (int k = 0; k < NTAP; k++)
         fir_acc += acc_t'($signed(raw_line[k])) * acc_t'(lpf_coef(k));
   end

   always_ff @(posedge clk) begin
      if (rst)         dec_line <= '0;
      else if (fir_en) dec_line <= {smp_t'(fir_acc >>> FIR_SHIFT), dec_line[NTAP-1:1]};
   end

endmodule

// File: rtl/ssbrx_mixout.sv
module ssbrx_mixout
   import ssbrx_pkg::*;
#(
   parameter int HIL_SHIFT = 12,
   parameter int DAC_MAX   = 250,
   parameter int LEVEL_W   = 8
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               go,
   input  smp_t [NTAP-1:0]    i_line,
   input  smp_t [NTAP-1:0]    q_line,
   output logic               out_valid,
   output logic [LEVEL_W-1:0] out_level
);

   localparam int   CTR     = NTAP / 2;
   localparam acc_t MID_OUT = acc_t'(DAC_MAX / 2);
   localparam acc_t TOP     = acc_t'(DAC_MAX);

   acc_t hil_acc, diff, half, lvl, clip;
   smp_t hil;

   always_comb begin
      hil_acc = '0;
      for (int k = 0; k < NTAP; k++)
         if (hil_coef(k) != 0)
            hil_acc += acc_t'($signed(q_line[k])) * acc_t'(hil_coef(k));
      hil  = smp_t'(hil_acc >>> HIL_SHIFT);
      diff = acc_t'($signed(i_line[CTR])) - acc_t'(hil);
      // halve with truncation toward zero
      half = (diff + ((diff < 0) ? acc_t'(1) : acc_t'(0))) >>> 1;
      lvl  = half + MID_OUT;
      if (lvl > TOP)      clip = TOP;
      else if (lvl < 0)   clip = '0;
      else                clip = lvl;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         out_valid <= 1'b0;
         out_level <= LEVEL_W'(DAC_MAX / 2);
      end else begin
         out_valid <= go;
         if (go) out_level <= LEVEL_W'(clip);
      end
   end

endmodule

// File: rtl/ssbrx_demod.sv
module ssbrx_demod
   import ssbrx_pkg::*;
#(
   parameter int SAMPLE_W  = 16,
   parameter int ADC_BITS  = 12,
   parameter int DC_SHIFT  = 7,
   parameter int DEC_LOG2  = 2,
   parameter int FIR_SHIFT = 8,
   parameter int HIL_SHIFT = 12,
   parameter int DAC_MAX   = 250,
   parameter int LEVEL_W   = 8
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [SAMPLE_W-1:0] in_i,
   input  logic [SAMPLE_W-1:0] in_q,
   output logic                out_valid,
   output logic [LEVEL_W-1:0]  out_level
);

   if (ADC_BITS > 15 || ADC_BITS < 2) begin : g_bad_adc
      $error("ssbrx_demod: ADC_BITS must lie in 2..15");
   end
   if (SAMPLE_W < ADC_BITS) begin : g_bad_w
      $error("ssbrx_demod: SAMPLE_W narrower than ADC_BITS");
   end
   if (DC_SHIFT < 1 || DC_SHIFT >= ADC_BITS) begin : g_bad_dc
      $error("ssbrx_demod: DC_SHIFT out of range");
   end
   if (DEC_LOG2 < 1) begin : g_bad_dec
      $error("ssbrx_demod: DEC_LOG2 must be at least 1");
   end
   if (DAC_MAX >= (1 << LEVEL_W) || DAC_MAX < 2) begin : g_bad_dac
      $error("ssbrx_demod: DAC_MAX does not fit LEVEL_W");
   end

   logic [DEC_LOG2-1:0] phase;
   logic                fir_go, hil_go;
   smp_t [NTAP-1:0]     dec_lines [2];

   always_ff @(posedge clk) begin
      if (rst) begin
         phase  <= '0;
         fir_go <= 1'b0;
         hil_go <= 1'b0;
      end else begin
         if (in_valid) phase <= phase + 1'b1;
         fir_go <= in_valid && (phase == '1);
         hil_go <= fir_go;
      end
   end

   for (genvar g = 0; g < 2; g++) begin : g_ch
      logic [SAMPLE_W-1:0] smp;
      assign smp = (g == 0) ? in_i : in_q;

      ssbrx_chan #(
         .SAMPLE_W  (SAMPLE_W),
         .ADC_BITS  (ADC_BITS),
         .DC_SHIFT  (DC_SHIFT),
         .FIR_SHIFT (FIR_SHIFT)
      ) u_chan (
         .clk      (clk),
         .rst      (rst),
         .smp_en   (in_valid),
         .fir_en   (fir_go),
         .sample   (smp),
         .dec_line (dec_lines[g])
      );
   end

   ssbrx_mixout #(
      .HIL_SHIFT (HIL_SHIFT),
      .DAC_MAX   (DAC_MAX),
      .LEVEL_W   (LEVEL_W)
   ) u_mix (
      .clk       (clk),
      .rst       (rst),
      .go        (hil_go),
      .i_line    (dec_lines[0]),
      .q_line    (dec_lines[1]),
      .out_valid (out_valid),
      .out_level (out_level)
   );

endmodule

// File: rtl/ssbrx_demod_chk.sv
module ssbrx_demod_chk #(
   parameter int DEC_LOG2 = 2,
   parameter int DAC_MAX  = 250,
   parameter int LEVEL_W  = 8
) (
   input logic                clk,
   input logic                rst,
   input logic                in_valid,
   input logic                out_valid,
   input logic [LEVEL_W-1:0]  out_level,
   input logic [DEC_LOG2-1:0] phase
);

   assert_level_range_R8: assert property (@(posedge clk) disable iff (rst)
      int'(out_level) <= DAC_MAX);

   assert_latency_R9: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid, 3));

   assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
      out_valid |=> !out_valid);

   assert_level_hold_R9: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> $stable(out_level));

   assert_phase_idle_R5: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(phase));

   assert_wrap_only_R5: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> ($past(phase, 3) == '1));

endmodule

bind ssbrx_demod ssbrx_demod_chk #(
   .DEC_LOG2 (DEC_LOG2),
   .DAC_MAX  (DAC_MAX),
   .LEVEL_W  (LEVEL_W)
) u_chk (
   .clk       (clk),
   .rst       (rst),
   .in_valid  (in_valid),
   .out_valid (out_valid),
   .out_level (out_level),
   .phase     (phase)
);

// File: tb/ssbrx_demod_tb.sv
`timescale 1ns/1ps
module ssbrx_demod_tb;

   localparam int NV = 6;
   localparam int NF = 7;
   // kind, amp_i, amp_q, period, count, idle gap, upper-bit value
   // kind: 0 constant, 1 square, 2 sawtooth, 3 sine (Q a quarter period ahead)
   localparam int VEC [NV][NF] = '{
      '{0,  2047,    0,  1, 200, 0,  0},
      '{0, -2048,    0,  1, 200, 0,  0},
      '{1,  1500, 1500, 16, 240, 0,  0},
      '{3,  1000, 1000, 40, 400, 0,  0},
      '{3,  1000, 1000, 40, 400, 2,  5},
      '{2,  1800,  900, 24, 301, 1,  0}
   };
   localparam int LPF [15] = '{3,3,5,7,9,10,11,11,11,10,9,7,5,3,3};

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [15:0] in_i = '0;
   logic [15:0] in_q = '0;
   logic        out_valid;
   logic [7:0]  out_level;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;
   bit seen_top = 1'b0;
   bit seen_bot = 1'b0;

   int got_q[$];
   int exp_q[$];

   int mdc [2];
   int mraw [2][15];
   int mdec [2][15];
   int mcnt;

   always #2.5 clk = ~clk;

   ssbrx_demod u_dut (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_i      (in_i),
      .in_q      (in_q),
      .out_valid (out_valid),
      .out_level (out_level)
   );

   always @(negedge clk) begin
      if (!rst && out_valid) got_q.push_back(int'(out_level));
   end

   task automatic check(bit ok, string req, string what, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic model_reset();
      mcnt = 0;
      for (int c = 0; c < 2; c++) begin
         mdc[c] = 0;
         for (int k = 0; k < 15; k++) begin
            mraw[c][k] = 0;
            mdec[c][k] = 0;
         end
      end
   endtask

   task automatic model_push(int vi, int vq);
      int v [2];
      int x, acc, h, d, lvl;
      v[0] = vi;
      v[1] = vq;
      for (int c = 0; c < 2; c++) begin
         x = (v[c] & 4095) - 2048;
         mdc[c] = mdc[c] + (x >>> 7) - (mdc[c] >>> 7);
         for (int k = 0; k < 14; k++) mraw[c][k] = mraw[c][k+1];
         mraw[c][14] = x - mdc[c];
      end
      mcnt = (mcnt + 1) % 4;
      if (mcnt == 0) begin
         for (int c = 0; c < 2; c++) begin
            acc = 0;
            for (int k = 0; k < 15; k++) acc += mraw[c][k] * LPF[k];
            for (int k = 0; k < 14; k++) mdec[c][k] = mdec[c][k+1];
            mdec[c][14] = acc >>> 8;
         end
         h = ((mdec[1][0] - mdec[1][14]) * 315 + (mdec[1][2] - mdec[1][12]) * 440 +
              (mdec[1][4] - mdec[1][10]) * 734 + (mdec[1][6] - mdec[1][8]) * 2202) >>> 12;
         d = mdec[0][7] - h;
         lvl = d / 2 + 125;
         if (lvl > 250) lvl = 250;
         if (lvl < 0) lvl = 0;
         exp_q.push_back(lvl);
      end
   endtask

   function automatic int gen(int kind, int amp, int per, int n, int off);
      int v;
      case (kind)
         0: v = 2048 + amp;
         1: v = (((n + off) / per) % 2 != 0) ? 2048 + amp : 2048 - amp;
         2: v = 2048 - amp + (2 * amp * ((n + off) % per)) / per;
         default: v = 2048 + int'(real'(amp) *
                      $sin(2.0 * 3.14159265358979 * real'(n + off) / real'(per)));
      endcase
      if (v > 4095) v = 4095;
      if (v < 0) v = 0;
      return v;
   endfunction

   task automatic do_reset();
      @(negedge clk);
      rst = 1'b1;
      in_valid = 1'b0;
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
      check(out_level == 8'd125, "R1", "out_level in reset", int'(out_level), 125);
      rst = 1'b0;
      model_reset();
      got_q.delete();
      exp_q.delete();
      @(negedge clk);
   endtask

   // called at a negedge; returns at a negedge
   task automatic drive(int vi, int vq, int gap);
      in_valid = 1'b1;
      in_i = 16'(vi);
      in_q = 16'(vq);
      model_push(vi, vq);
      @(negedge clk);
      if (gap > 0) begin
         in_valid = 1'b0;
         repeat (gap) begin
            in_i = 16'($urandom);
            in_q = 16'($urandom);
            @(negedge clk);
         end
      end
   endtask

   task automatic run_vec(int kind, int ai, int aq, int per, int cnt, int gap, int hi);
      int vi, vq, qoff;
      do_reset();
      qoff = (kind == 3) ? per / 4 : 0;
      for (int n = 0; n < cnt; n++) begin
         vi = gen(kind, ai, per, n, 0) | (hi << 12);
         vq = gen(kind, aq, per, n, qoff) | (hi << 12);
         drive(vi, vq, gap);
      end
      in_valid = 1'b0;
      repeat (6) @(negedge clk);
      check(got_q.size() == cnt / 4, "R5", "output count", got_q.size(), cnt / 4);
      for (int k = 0; k < got_q.size() && k < exp_q.size(); k++) begin
         check(got_q[k] == exp_q[k], "R3 R4 R6 R7 R8", "level", got_q[k], exp_q[k]);
         if (got_q[k] == 250) seen_top = 1'b1;
         if (got_q[k] == 0) seen_bot = 1'b1;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      int ref_lv [$];
      model_reset();

      // table-driven runs
      for (int v = 0; v < NV; v++)
         run_vec(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6]);

      // R8: rails reached by the full-scale steps
      check(seen_top, "R8", "upper rail reached", int'(seen_top), 1);
      check(seen_bot, "R8", "lower rail reached", int'(seen_bot), 1);

      // R2: upper input bits have no effect
      run_vec(1, 1200, 700, 12, 160, 0, 0);
      ref_lv = got_q;
      run_vec(1, 1200, 700, 12, 160, 0, 15);
      check(got_q.size() == ref_lv.size(), "R2", "count with upper bits", got_q.size(), ref_lv.size());
      for (int k = 0; k < got_q.size() && k < ref_lv.size(); k++)
         check(got_q[k] == ref_lv[k], "R2", "level with upper bits", got_q[k], ref_lv[k]);

      // R5: idle cycles with junk data produce nothing
      do_reset();
      repeat (40) begin
         in_i = 16'($urandom);
         in_q = 16'($urandom);
         @(negedge clk);
      end
      check(got_q.size() == 0, "R5", "outputs while idle", got_q.size(), 0);
      check(out_level == 8'd125, "R5", "level while idle", int'(out_level), 125);

      // R5/R9: three samples with gaps, then the fourth; exact latency
      for (int n = 0; n < 3; n++) drive(3000, 1000, 5);
      check(got_q.size() == 0, "R5", "outputs after three samples", got_q.size(), 0);
      in_valid = 1'b1;
      in_i = 16'd3000;
      in_q = 16'd1000;
      model_push(3000, 1000);
      @(negedge clk);
      in_valid = 1'b0;
      check(out_valid == 1'b0, "R9", "out_valid one edge later", int'(out_valid), 0);
      @(negedge clk);
      check(out_valid == 1'b0, "R9", "out_valid two edges later", int'(out_valid), 0);
      @(negedge clk);
      check(out_valid == 1'b1, "R9", "out_valid three edges later", int'(out_valid), 1);
      check(int'(out_level) == exp_q[0], "R7", "first level", int'(out_level), exp_q[0]);
      @(negedge clk);
      check(out_valid == 1'b0, "R9", "pulse width", int'(out_valid), 0);
      repeat (5) @(negedge clk);
      check(got_q.size() == 1, "R5", "outputs after four samples", got_q.size(), 1);
      check(int'(out_level) == exp_q[0], "R9", "level held", int'(out_level), exp_q[0]);

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule